// File: doc/BRIEF.md
# Tile Row Pixel Decoder

This block turns one tile name word plus a pixel row number (0 to 7) into the eight palette indices of that row of an 8x8 tile. It reads the pattern data itself from a 1 MB tile memory that is organised as 32-bit words. A per-layer depth setting chooses between two pixel depths. In 4-bit mode a tile takes 8 words and each row is one word. In 8-bit mode a tile takes 16 words and each row is two consecutive words. The pixel depth decides how the pattern address is built and how many name-word bits feed the upper part of each palette index.

An upstream tilemap walker presents the name word, the row and the layer number with a valid/ready handshake. The block computes the word address of the row and issues one or two single-word reads. Each read is held until it is granted, and only one read is outstanding at a time. The block then hands out the eight 15-bit palette indices in screen order, leftmost first. In 8-bit mode the left four pixels leave while the right-hand word is still being fetched. A new name word is taken only after the eighth pixel has been handed off.

Top module: `tile_row_decoder`

## Requirements
- R1: `ent_ready_o` is high exactly when no tile row is in progress. A name word is taken on a cycle with `ent_valid_i` and `ent_ready_o` both high. The first read request is raised in the cycle after that.
- R2: In 4-bit mode exactly one read is made, at word address `P*8 + row`. Here `P` is the 15-bit pattern number formed as name bits 13:0 shifted up by one, with name bit 15 placed in the least significant bit.
- R3: In 8-bit mode two reads are made. The first goes to word address `name[13:0]*16 + row*2` and the second to that address plus 1. Name bits 15 and 14 play no part in the address.
- R4: The depth is `depth_cfg_i[ent_layer_i]`, with layer codes 0..3 and 1 meaning 4-bit and 0 meaning 8-bit. It is sampled only in the acceptance cycle, so later changes to `depth_cfg_i` do not affect the row in progress.
- R5: In 4-bit mode, pixel k (k = 0 leftmost) is bits `31-4k` down to `28-4k` of the row word.
- R6: In 4-bit mode the palette index is name bits 14:4 concatenated above the 4-bit pixel value.
- R7: In 8-bit mode, pixels 0..3 come from the first word and pixels 4..7 from the second word. In each word the leftmost pixel sits in bits 31:24 and the rightmost in bits 7:0.
- R8: In 8-bit mode the palette index is name bits 14:8 concatenated above the 8-bit pixel value.
- R9: Pixels leave in order 0..7 on `pix_valid_o`/`pix_ready_i`. While ready is low, valid and the index hold. `pix_last_o` marks pixel 7 only.
- R10: `mem_req_o` and `mem_addr_o` hold until a cycle with `mem_gnt_i` high. Data is taken on the first `mem_rvalid_i` after the grant, and no further read is raised before that.
- R11: In 8-bit mode the second read is raised in the cycle after the first word returns. Pixels 0..3 may be handed off while that read is still outstanding.
- R12: After reset, `ent_ready_o` is high and `mem_req_o` and `pix_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ent_valid_i | input | 1 | Name word offered |
| ent_ready_o | output | 1 | Block idle, name word can be taken |
| ent_name_i | input | 16 | Tile name word |
| ent_row_i | input | 3 | Pixel row within the tile |
| ent_layer_i | input | 2 | Layer code selecting the depth bit |
| depth_cfg_i | input | 4 | Per-layer depth bits, 1 = 4-bit |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 18 | Word address of the read |
| mem_gnt_i | input | 1 | Read request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| pix_valid_o | output | 1 | Palette index valid |
| pix_ready_i | input | 1 | Consumer takes the index |
| pix_idx_o | output | 15 | Palette index |
| pix_last_o | output | 1 | Index is the row's eighth pixel |

## Verification
In 8-bit mode the return of the second word can land in the same cycle as the hand-off of one of pixels 0..3. Both touch the pixel store: one loads the right half, the other advances the read pointer through the left half. The bench provokes this by granting every request at once, stretching the read latency to several cycles and holding the consumer ready. It then runs random grant, latency and back-pressure patterns. Every handed-off index is compared with a queue filled at acceptance from the address rules and a computed memory image. The bench also requires that some pixels were handed off while a read was still outstanding.

// File: rtl/tile_dec_pkg.sv
package tile_dec_pkg;
  localparam int NAME_W  = 16;
  localparam int ROW_W   = 3;
  localparam int LAYER_N = 4;
  localparam int LAYER_W = $clog2(LAYER_N);
  localparam int ADDR_W  = 18;
  localparam int WORD_W  = 32;
  localparam int PIX_N   = 8;
  localparam int CNT_W   = $clog2(PIX_N);
  localparam int SLOT_W  = 8;
  localparam int NIB_W   = WORD_W / PIX_N;
  localparam int BYTE_N  = WORD_W / SLOT_W;
  localparam int PAL_W   = 15;
  localparam int PAT_W   = 15;  // name bit 15 on top, bits 13:0 below
  localparam int PHI_W   = 11;  // name bits 14:4

  typedef logic [SLOT_W-1:0] slot_t;
  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fetch_st_e;

  // pat = {name[15], name[13:0]}
  function automatic logic [ADDR_W-1:0] row_addr(input logic [PAT_W-1:0] pat,
                                                 input logic [ROW_W-1:0] row,
                                                 input logic m4, input logic hi);
    if (m4) return {pat[13:0], pat[14], row};
    return {pat[13:0], row, hi};
  endfunction

  // phi = name[14:4]
  function automatic logic [PAL_W-1:0] pal_idx(input logic [PHI_W-1:0] phi,
                                               input slot_t slot, input logic m4);
    if (m4) return {phi, slot[NIB_W-1:0]};
    return {phi[PHI_W-1:4], slot};
  endfunction
endpackage

// File: rtl/tile_dec_fetch.sv
module tile_dec_fetch
  import tile_dec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              m4_i,
  input  logic [PAT_W-1:0]  pat_i,
  input  logic [ROW_W-1:0]  row_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  output logic              load_o,
  output logic              load_hi_o
);
  fetch_st_e st_q;
  logic      hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= F_IDLE;
      hi_q <= 1'b0;
    end else begin
      case (st_q)
        F_IDLE: if (start_i) begin
          st_q <= F_REQ;
          hi_q <= 1'b0;
        end
        F_REQ: if (mem_gnt_i) st_q <= F_WAIT;
        F_WAIT: if (mem_rvalid_i) begin
          if (!m4_i && !hi_q) begin
            hi_q <= 1'b1;
            st_q <= F_REQ;
          end else begin
            st_q <= F_IDLE;
          end
        end
        default: st_q <= F_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (st_q == F_REQ);
  assign mem_addr_o = row_addr(pat_i, row_i, m4_i, hi_q);
  assign load_o     = (st_q == F_WAIT) && mem_rvalid_i;
  assign load_hi_o  = hi_q;
endmodule

// File: rtl/tile_dec_unpack.sv
module tile_dec_unpack
  import tile_dec_pkg::*;
(
  input  logic [WORD_W-1:0]             word_i,
  output logic [PIX_N-1:0][SLOT_W-1:0]  nib_o,
  output logic [BYTE_N-1:0][SLOT_W-1:0] byte_o
);
  for (genvar k = 0; k < PIX_N; k++) begin : g_nib
    assign nib_o[k] = {{(SLOT_W-NIB_W){1'b0}}, word_i[WORD_W-1-NIB_W*k -: NIB_W]};
  end
  for (genvar k = 0; k < BYTE_N; k++) begin : g_byte
    assign byte_o[k] = word_i[WORD_W-1-SLOT_W*k -: SLOT_W];
  end
endmodule

// File: rtl/tile_dec_emit.sv
module tile_dec_emit
  import tile_dec_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic                          m4_i,
  input  logic [PHI_W-1:0]              phi_i,
  input  logic                          load_i,
  input  logic                          load_hi_i,
  input  logic [PIX_N-1:0][SLOT_W-1:0]  nib_i,
  input  logic [BYTE_N-1:0][SLOT_W-1:0] byte_i,
  output logic                          pix_valid_o,
  input  logic                          pix_ready_i,
  output logic [PAL_W-1:0]              pix_idx_o,
  output logic                          pix_last_o,
  output logic                          done_o
);
  logic [PIX_N-1:0][SLOT_W-1:0] slot_q;
  logic                         lo_ok_q, hi_ok_q;
  logic [CNT_W-1:0]             cnt_q;
  logic                         fire;

  assign pix_valid_o = cnt_q[CNT_W-1] ? hi_ok_q : lo_ok_q;
  assign fire        = pix_valid_o && pix_ready_i;
  assign pix_last_o  = (cnt_q == CNT_W'(PIX_N-1));
  assign done_o      = fire && pix_last_o;
  assign pix_idx_o   = pal_idx(phi_i, slot_q[cnt_q], m4_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= '0;
      lo_ok_q <= 1'b0;
      hi_ok_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (load_i) begin
        if (m4_i) begin
          slot_q  <= nib_i;
          lo_ok_q <= 1'b1;
          hi_ok_q <= 1'b1;
        end else if (!load_hi_i) begin
          for (int k = 0; k < BYTE_N; k++) slot_q[k] <= byte_i[k];
          lo_ok_q <= 1'b1;
        end else begin
          for (int k = 0; k < BYTE_N; k++) slot_q[BYTE_N+k] <= byte_i[k];
          hi_ok_q <= 1'b1;
        end
      end
      if (fire) cnt_q <= cnt_q + 1'b1;
      if (done_o || start_i) begin
        lo_ok_q <= 1'b0;
        hi_ok_q <= 1'b0;
        cnt_q   <= '0;
      end
    end
  end
endmodule

// File: rtl/tile_row_decoder.sv
module tile_row_decoder
  import tile_dec_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ent_valid_i,
  output logic               ent_ready_o,
  input  logic [NAME_W-1:0]  ent_name_i,
  input  logic [ROW_W-1:0]   ent_row_i,
  input  logic [LAYER_W-1:0] ent_layer_i,
  input  logic [LAYER_N-1:0] depth_cfg_i,
  output logic               mem_req_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  input  logic               mem_gnt_i,
  input  logic               mem_rvalid_i,
  input  logic [WORD_W-1:0]  mem_rdata_i,
  output logic               pix_valid_o,
  input  logic               pix_ready_i,
  output logic [PAL_W-1:0]   pix_idx_o,
  output logic               pix_last_o
);
  logic               busy_q, m4_q, accept, done, load, load_hi;
  logic [NAME_W-1:0]  name_q;
  logic [ROW_W-1:0]   row_q;
  logic [PIX_N-1:0][SLOT_W-1:0]  nib;
  logic [BYTE_N-1:0][SLOT_W-1:0] bytes;

  assign ent_ready_o = !busy_q;
  assign accept      = ent_valid_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      m4_q   <= 1'b0;
      name_q <= '0;
      row_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      m4_q   <= depth_cfg_i[ent_layer_i];
      name_q <= ent_name_i;
      row_q  <= ent_row_i;
    end else if (done) begin
      busy_q <= 1'b0;
    end
  end

  tile_dec_fetch i_fetch (
    .clk_i, .rst_ni,
    .start_i     (accept),
    .m4_i        (m4_q),
    .pat_i       ({name_q[15], name_q[13:0]}),
    .row_i       (row_q),
    .mem_req_o, .mem_addr_o, .mem_gnt_i, .mem_rvalid_i,
    .load_o      (load),
    .load_hi_o   (load_hi)
  );

  tile_dec_unpack i_unpack (
    .word_i (mem_rdata_i),
    .nib_o  (nib),
    .byte_o (bytes)
  );

  tile_dec_emit i_emit (
    .clk_i, .rst_ni,
    .start_i     (accept),
    .m4_i        (m4_q),
    .phi_i       (name_q[14:4]),
    .load_i      (load),
    .load_hi_i   (load_hi),
    .nib_i       (nib),
    .byte_i      (bytes),
    .pix_valid_o, .pix_ready_i, .pix_idx_o, .pix_last_o,
    .done_o      (done)
  );
endmodule

// File: rtl/tile_row_decoder_chk.sv
module tile_row_decoder_chk
  import tile_dec_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ent_valid_i,
  input logic              ent_ready_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_gnt_i,
  input logic              pix_valid_o,
  input logic              pix_ready_i,
  input logic [PAL_W-1:0]  pix_idx_o,
  input logic              pix_last_o
);
  // R1
  accept_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_valid_i && ent_ready_o |=> mem_req_o);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_ready_o |-> !mem_req_o && !pix_valid_o);
  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o));
  // R9
  pix_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && !pix_ready_i |=> pix_valid_o && $stable(pix_idx_o) && $stable(pix_last_o));
  // R9
  last_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && pix_ready_i && pix_last_o |=> ent_ready_o);
  // R9
  last_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_last_o && pix_valid_o |-> !ent_ready_o);
endmodule

bind tile_row_decoder tile_row_decoder_chk i_chk (
  .clk_i, .rst_ni, .ent_valid_i, .ent_ready_o, .mem_req_o, .mem_addr_o, .mem_gnt_i,
  .pix_valid_o, .pix_ready_i, .pix_idx_o, .pix_last_o
);

// File: tb/test_tile_row_decoder.sv
`timescale 1ns/1ps
module test_tile_row_decoder;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ent_valid = 1'b0, ent_ready;
  logic [15:0] ent_name = '0;
  logic [2:0]  ent_row = '0;
  logic [1:0]  ent_layer = '0;
  logic [3:0]  depth_cfg = '0;
  logic        mem_req, mem_gnt, mem_rvalid;
  logic [17:0] mem_addr;
  logic [31:0] mem_rdata;
  logic        pix_valid, pix_ready, pix_last;
  logic [14:0] pix_idx;

  int tests = 0, fails = 0;
  int gnt_mode = 0, lat_mode = 0, rdy_mode = 0;
  int overlap = 0, pix_cnt = 0;
  bit done = 1'b0, exp_busy = 1'b0;
  logic [31:0] rnd = 32'h1ACE_B00C;
  logic        pend = 1'b0;
  int          wait_n = 0;
  logic [17:0] paddr = '0;
  int unsigned addr_q[$], pix_q[$];
  string       atag_q[$], ptag_q[$];

  always #2 clk = ~clk;

  tile_row_decoder i_tile_row_decoder (
    .clk_i(clk), .rst_ni(rst_n),
    .ent_valid_i(ent_valid), .ent_ready_o(ent_ready), .ent_name_i(ent_name),
    .ent_row_i(ent_row), .ent_layer_i(ent_layer), .depth_cfg_i(depth_cfg),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_gnt_i(mem_gnt),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .pix_valid_o(pix_valid), .pix_ready_i(pix_ready), .pix_idx_o(pix_idx),
    .pix_last_o(pix_last)
  );

  function automatic logic [31:0] mem_word(input int unsigned a);
    return a * 32'h9E37_79B1 + 32'h0123_4567;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural memory, consumer ready and reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_gnt <= 1'b0; mem_rvalid <= 1'b0; mem_rdata <= '0; pix_ready <= 1'b0;
      pend <= 1'b0; exp_busy <= 1'b0;
    end else begin
      rnd <= {rnd[30:0], rnd[31] ^ rnd[21] ^ rnd[1] ^ rnd[0]};
      mem_rvalid <= 1'b0;
      if (pend) begin
        if (wait_n == 0) begin
          mem_rvalid <= 1'b1; mem_rdata <= mem_word(paddr); pend <= 1'b0;
        end else wait_n <= wait_n - 1;
      end else if (mem_req && mem_gnt) begin
        pend <= 1'b1; paddr <= mem_addr;
        wait_n <= (lat_mode == 0) ? 0 : (lat_mode == 1) ? 3 : int'(rnd[5:4]);
      end
      mem_gnt   <= (gnt_mode == 0) ? 1'b1 : rnd[3];
      pix_ready <= (rdy_mode == 0) ? 1'b1 : (rnd[9] | rnd[12]);
      if (ent_valid && ent_ready) begin
        automatic bit m4 = depth_cfg[ent_layer];
        automatic int unsigned base, w;
        exp_busy <= 1'b1;
        if (m4) begin
          base = ({ent_name[13:0], 1'b0} | ent_name[15]) * 8 + ent_row;
          addr_q.push_back(base); atag_q.push_back("R2,R4 addr");
          w = mem_word(base);
          for (int k = 0; k < 8; k++) begin
            pix_q.push_back((ent_name & 16'h7FF0) | ((w >> (28 - 4*k)) & 4'hF));
            ptag_q.push_back("R5,R6 pixel");
          end
        end else begin
          base = ent_name[13:0] * 16 + ent_row * 2;
          for (int h = 0; h < 2; h++) begin
            addr_q.push_back(base + h); atag_q.push_back("R3,R4 addr");
            w = mem_word(base + h);
            for (int k = 0; k < 4; k++) begin
              pix_q.push_back((ent_name & 16'h7F00) | ((w >> (24 - 8*k)) & 8'hFF));
              ptag_q.push_back("R7,R8 pixel");
            end
          end
        end
      end else if (pix_valid && pix_ready && pix_last) exp_busy <= 1'b0;
    end
  end

  // comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(ent_ready == !exp_busy, "R1 ent_ready", ent_ready, !exp_busy);
      if (mem_req && mem_gnt) begin
        if (addr_q.size() == 0) chk(1'b0, "R10 unexpected read", mem_addr, 0);
        else begin
          automatic int unsigned ea = addr_q.pop_front();
          automatic string t = atag_q.pop_front();
          chk(mem_addr == ea, t, mem_addr, ea);
        end
      end
      if (pix_valid && pix_ready) begin
        if (pend || mem_req) overlap++;
        if (pix_q.size() == 0) chk(1'b0, "R9 unexpected pixel", pix_idx, 0);
        else begin
          automatic int unsigned ep = pix_q.pop_front();
          automatic string t = ptag_q.pop_front();
          chk(pix_idx == ep, t, pix_idx, ep);
          chk(pix_last == (pix_cnt % 8 == 7), "R9 last flag", pix_last, pix_cnt % 8 == 7);
        end
        pix_cnt++;
      end
    end
  end

  task automatic send(input logic [15:0] n, input logic [2:0] r, input logic [1:0] l,
                      input logic [3:0] cfg);
    @(negedge clk);
    ent_name = n; ent_row = r; ent_layer = l; depth_cfg = cfg; ent_valid = 1'b1;
    while (!ent_ready) @(negedge clk);
    @(negedge clk);
    ent_valid = 1'b0;
    depth_cfg = ~cfg;  // R4: must not affect the row in progress
  endtask

  task automatic drain();
    while (exp_busy || pix_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(ent_ready == 1'b1, "R12 ent_ready", ent_ready, 1);
    chk(mem_req == 1'b0, "R12 mem_req", mem_req, 0);
    chk(pix_valid == 1'b0, "R12 pix_valid", pix_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // 4-bit, top name bit rotates into pattern LSB
    send(16'h8001, 3'd0, 2'd0, 4'b0001);
    send(16'h4FF5, 3'd7, 2'd1, 4'b0010);
    // 8-bit, highest address, layer code 3
    send(16'hFFFF, 3'd7, 2'd3, 4'b0111);
    send(16'h3A5C, 3'd2, 2'd2, 4'b1011);
    drain();
    // R11: long read latency, consumer always ready
    lat_mode = 1; overlap = 0;
    send(16'h1234, 3'd5, 2'd0, 4'b0000);
    send(16'hC0DE, 3'd1, 2'd1, 4'b0000);
    drain();
    chk(overlap > 0, "R11 pixels during second read", overlap, 1);
    // random grant, latency and back-pressure
    gnt_mode = 1; lat_mode = 2; rdy_mode = 1;
    for (int i = 0; i < 150; i++)
      send(rnd[31:16] ^ 16'(i * 7919), rnd[6:4], rnd[8:7], rnd[13:10]);
    drain();
    chk(addr_q.size() == 0, "R10 reads outstanding", addr_q.size(), 0);
    chk(pix_q.size() == 0, "R9 pixels missing", pix_q.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL R1 watchdog act=%0h exp=%0h", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule